// File: doc/BRIEF.md
# Timed Flow Header Builder

This block turns one dispatched packet request into a transmit request carrying a fully resolved header descriptor. A request names a flow and a 16-bit departure time. The block reads the flow's four-word descriptor, picks a source and a destination address from two per-flow address lists, and assembles port, protocol, type-of-service, layer-4 port and address fields. It then holds that header until a free-running 16-bit tick counter reaches the departure time. At that point it issues a single-cycle transmit request.

Each address list is served either by a stored rotating index, which the block advances and writes back into the descriptor, or by a 16-bit LFSR reduced modulo the list length. The mode is chosen per list by two bits of the descriptor. Only one request is in flight at a time. The block accepts a new request once the previous transmit request has been issued.

Top module: `tfhb_builder`

## Requirements
- R1: After reset, `req_ready_o` is 1, `tx_valid_o` is 0 and neither memory is read until a request is accepted.
- R2: Descriptor word w (0..3) of flow f is read at address {f, w[1:0]}, and read data is returned one cycle after the read enable. Word 0 carries the output port in bits 31-23, the protocol in 22-15, the TOS in 14-7 and the selection mode in 6-5, and bits 4-0 are ignored. These fields appear unchanged on `tx_port_o`, `tx_proto_o` and `tx_tos_o`. The descriptor port never reads and writes in the same cycle.
- R3: Word 1 bits 31-16 appear on `tx_sport_o` and bits 15-0 on `tx_dport_o`.
- R4: Words 2 (source list) and 3 (destination list) each hold a next index in bits 31-24, a total in 23-16 and a list pointer in 15-0. Mode bit 5 selects the source mode and bit 6 the destination mode, with 0 meaning linear. In linear mode the address read is at (pointer + next index) mod 2^16, and the returned word appears on `tx_saddr_o` or `tx_daddr_o`.
- R5: After a linear pick, the same descriptor word is written back with total and pointer unchanged. The next index becomes index+1, or 0 once index+1 is not below the total.
- R6: In random mode the index is the LFSR value modulo the total, and no write-back occurs. The LFSR starts at `LFSR_SEED` (default 16'hACE1) and shifts left with new bit 0 = b15^b13^b12^b10. It advances once after each random-mode pick, and the source pick precedes the destination pick.
- R7: A list whose total is 0 uses index 0 in either mode. A linear write-back for such a list stores next index 0.
- R8: `req_ready_o` falls in the cycle after a request is accepted and stays 0 until the transmit request has been issued.
- R9: The tick counter resets to 0, increments by one in each cycle in which `tick_i` is 1, and wraps from 16'hFFFF to 0.
- R10: While a header is held, `tx_valid_o` pulses for exactly one cycle, one cycle after the counter value makes (time − counter), read as signed 16 bits, zero or negative. This includes targets already in the past and targets across the counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Advances the tick counter |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_flow_i | input | FLOW_W | Flow index of the request |
| req_time_i | input | 16 | Departure time in ticks |
| desc_rd_en_o | output | 1 | Descriptor memory read enable |
| desc_addr_o | output | FLOW_W+2 | Descriptor word address, read or write |
| desc_rd_data_i | input | 32 | Descriptor read data, one cycle latency |
| desc_wr_en_o | output | 1 | Descriptor index write-back enable |
| desc_wr_data_o | output | 32 | Descriptor write-back data |
| alist_rd_en_o | output | 1 | Address-list memory read enable |
| alist_addr_o | output | 16 | Address-list word address |
| alist_rd_data_i | input | 32 | Address-list read data, one cycle latency |
| tx_valid_o | output | 1 | Transmit request pulse |
| tx_port_o | output | 9 | Output port |
| tx_proto_o | output | 8 | Protocol |
| tx_tos_o | output | 8 | Type of service |
| tx_sport_o | output | 16 | Source layer-4 port |
| tx_dport_o | output | 16 | Destination layer-4 port |
| tx_saddr_o | output | 32 | Selected source address |
| tx_daddr_o | output | 32 | Selected destination address |

## Verification
A request needs eight cycles from acceptance to a held header. Once the header is held, a tick that brings the counter to the target produces `tx_valid_o` one cycle after that tick's edge. The bench keeps ticks idle for ten cycles after each request, so the early-release checks happen while the header is being built. It then steps the counter one tick at a time and samples two falling edges after each tick, expecting the pulse only on the step that reaches the target. Targets already due are polled for a bounded number of cycles. Index write-backs are checked in the bench's descriptor memory after each pulse, and LFSR-based picks are predicted by a model of R6 in the bench.

// File: rtl/tfhb_pkg.sv
package tfhb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_RD3,
    ST_SRC,
    ST_DST,
    ST_DCAP,
    ST_WAIT
  } tfhb_state_e;

  typedef struct packed {
    logic [7:0]  nidx;
    logic [7:0]  total;
    logic [15:0] ptr;
  } tfhb_list_t;

endpackage

// File: rtl/tfhb_lfsr.sv
module tfhb_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] value_o
);

  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step_i) lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr_q <= SEED;
    else if (step_i) lfsr_q <= lfsr_d;
  end

  assign value_o = lfsr_q;

  // R6: the sequence never locks up in the all-zero state
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/tfhb_idx_sel.sv
module tfhb_idx_sel #(
  parameter int IW = 8,
  parameter int RW = 16
) (
  input  logic          rand_i,
  input  logic [IW-1:0] nidx_i,
  input  logic [IW-1:0] total_i,
  input  logic [RW-1:0] rnd_i,
  output logic [IW-1:0] use_o,
  output logic [IW-1:0] wb_o
);

  localparam int PADW = RW - IW;

  logic [IW:0]   inc;
  logic [RW-1:0] rem;
  logic          empty;

  always_comb begin
    empty = (total_i == '0);
    inc   = {1'b0, nidx_i} + 1'b1;
    rem   = empty ? '0 : (rnd_i % {{PADW{1'b0}}, total_i});
    if (empty)       use_o = '0;
    else if (rand_i) use_o = rem[IW-1:0];
    else             use_o = nidx_i;
    if (empty || (inc >= {1'b0, total_i})) wb_o = '0;
    else                                   wb_o = inc[IW-1:0];
  end

endmodule

// File: rtl/tfhb_due.sv
module tfhb_due #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [TW-1:0] target_i,
  output logic [TW-1:0] now_o,
  output logic          due_o
);

  logic [TW-1:0] now_q, now_d, diff;

  always_comb begin
    now_d = now_q + 1'b1;
    diff  = target_i - now_q;
    due_o = diff[TW-1] || (diff == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      now_q <= '0;
    else if (tick_i) now_q <= now_d;
  end

  assign now_o = now_q;

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> now_q == $past(now_q) + 1'b1);
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(now_q));

endmodule

// File: rtl/tfhb_builder.sv
module tfhb_builder
  import tfhb_pkg::*;
#(
  parameter int          FLOW_W    = 15,
  parameter int          TW        = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [FLOW_W-1:0]   req_flow_i,
  input  logic [TW-1:0]       req_time_i,
  output logic                desc_rd_en_o,
  output logic [FLOW_W+1:0]   desc_addr_o,
  input  logic [31:0]         desc_rd_data_i,
  output logic                desc_wr_en_o,
  output logic [31:0]         desc_wr_data_o,
  output logic                alist_rd_en_o,
  output logic [15:0]         alist_addr_o,
  input  logic [31:0]         alist_rd_data_i,
  output logic                tx_valid_o,
  output logic [8:0]          tx_port_o,
  output logic [7:0]          tx_proto_o,
  output logic [7:0]          tx_tos_o,
  output logic [15:0]         tx_sport_o,
  output logic [15:0]         tx_dport_o,
  output logic [31:0]         tx_saddr_o,
  output logic [31:0]         tx_daddr_o
);

  localparam int IW = 8;
  localparam int RW = 16;

  tfhb_state_e      state_q, state_d;
  logic [FLOW_W-1:0] flow_q;
  logic [TW-1:0]    time_q;
  logic [31:0]      w0_q, w1_q, saddr_q, daddr_q;
  tfhb_list_t       src_q, dst_q, sel_list;
  logic             txv_q, txv_d;
  logic             accept, cap_w0, cap_w1, cap_src, cap_dst, cap_sa, cap_da;
  logic [1:0]       word_sel;
  logic             sel_rand, lfsr_step, due;
  logic [RW-1:0]    rnd;
  logic [IW-1:0]    use_idx, wb_idx;
  logic [TW-1:0]    now;

  tfhb_lfsr #(.W(RW), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(lfsr_step), .value_o(rnd)
  );

  tfhb_idx_sel #(.IW(IW), .RW(RW)) u_sel (
    .rand_i(sel_rand), .nidx_i(sel_list.nidx), .total_i(sel_list.total),
    .rnd_i(rnd), .use_o(use_idx), .wb_o(wb_idx)
  );

  tfhb_due #(.TW(TW)) u_due (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .target_i(time_q),
    .now_o(now), .due_o(due)
  );

  // next-state and control
  always_comb begin
    state_d       = state_q;
    accept        = 1'b0;
    cap_w0        = 1'b0;
    cap_w1        = 1'b0;
    cap_src       = 1'b0;
    cap_dst       = 1'b0;
    cap_sa        = 1'b0;
    cap_da        = 1'b0;
    desc_rd_en_o  = 1'b0;
    desc_wr_en_o  = 1'b0;
    alist_rd_en_o = 1'b0;
    word_sel      = 2'd0;
    txv_d         = 1'b0;
    sel_list      = (state_q == ST_SRC) ? src_q : dst_q;
    sel_rand      = (state_q == ST_SRC) ? w0_q[5] : w0_q[6];
    lfsr_step     = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin accept = 1'b1; state_d = ST_RD0; end
      ST_RD0:  begin desc_rd_en_o = 1'b1; word_sel = 2'd0; state_d = ST_RD1; end
      ST_RD1:  begin desc_rd_en_o = 1'b1; word_sel = 2'd1; cap_w0 = 1'b1; state_d = ST_RD2; end
      ST_RD2:  begin desc_rd_en_o = 1'b1; word_sel = 2'd2; cap_w1 = 1'b1; state_d = ST_RD3; end
      ST_RD3:  begin desc_rd_en_o = 1'b1; word_sel = 2'd3; cap_src = 1'b1; state_d = ST_SRC; end
      ST_SRC: begin
        cap_dst       = 1'b1;
        alist_rd_en_o = 1'b1;
        word_sel      = 2'd2;
        desc_wr_en_o  = !sel_rand;
        lfsr_step     = sel_rand;
        state_d       = ST_DST;
      end
      ST_DST: begin
        cap_sa        = 1'b1;
        alist_rd_en_o = 1'b1;
        word_sel      = 2'd3;
        desc_wr_en_o  = !sel_rand;
        lfsr_step     = sel_rand;
        state_d       = ST_DCAP;
      end
      ST_DCAP: begin cap_da = 1'b1; state_d = ST_WAIT; end
      ST_WAIT: if (due) begin txv_d = 1'b1; state_d = ST_IDLE; end
      default: state_d = ST_IDLE;
    endcase
    desc_addr_o    = {flow_q, word_sel};
    alist_addr_o   = sel_list.ptr + {{(RW-IW){1'b0}}, use_idx};
    desc_wr_data_o = {wb_idx, sel_list.total, sel_list.ptr};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      txv_q   <= 1'b0;
      flow_q  <= '0;
      time_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      saddr_q <= '0;
      daddr_q <= '0;
    end else begin
      state_q <= state_d;
      txv_q   <= txv_d;
      if (accept)  begin flow_q <= req_flow_i; time_q <= req_time_i; end
      if (cap_w0)  w0_q    <= desc_rd_data_i;
      if (cap_w1)  w1_q    <= desc_rd_data_i;
      if (cap_src) src_q   <= desc_rd_data_i;
      if (cap_dst) dst_q   <= desc_rd_data_i;
      if (cap_sa)  saddr_q <= alist_rd_data_i;
      if (cap_da)  daddr_q <= alist_rd_data_i;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign tx_valid_o  = txv_q;
  assign tx_port_o   = w0_q[31:23];
  assign tx_proto_o  = w0_q[22:15];
  assign tx_tos_o    = w0_q[14:7];
  assign tx_sport_o  = w1_q[31:16];
  assign tx_dport_o  = w1_q[15:0];
  assign tx_saddr_o  = saddr_q;
  assign tx_daddr_o  = daddr_q;

  p_no_rw_clash_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_rd_en_o && desc_wr_en_o));
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  p_tx_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |=> !tx_valid_o);
  p_tx_after_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(state_q) == ST_WAIT);
  p_wb_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en_o |-> (desc_wr_data_o[31:24] < desc_wr_data_o[23:16]) ||
                     (desc_wr_data_o[31:24] == 8'd0));
  p_rand_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alist_rd_en_o && sel_rand && sel_list.total != 8'd0) |->
      (alist_addr_o - sel_list.ptr) < {8'd0, sel_list.total});

endmodule

// File: tb/tfhb_builder_bench.sv
module tfhb_builder_bench;

  localparam int NV = 8;
  // each row: flow (2 bits), signed tick offset of the target from now (16 bits)
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 16'd3},  {2'd0, 16'd2},  {2'd1, 16'd4},  {2'd1, 16'd1},
    {2'd2, 16'd2},  {2'd3, 16'd0},  {2'd3, 16'hFFFB}, {2'd0, 16'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_flow = '0;
  logic [15:0] req_time = '0;
  logic        drd_en, dwr_en, ard_en, tx_valid;
  logic [16:0] daddr;
  logic [31:0] drd_data, dwr_data, ard_data;
  logic [15:0] aaddr;
  logic [8:0]  tx_port;
  logic [7:0]  tx_proto, tx_tos;
  logic [15:0] tx_sport, tx_dport;
  logic [31:0] tx_saddr, tx_daddr;

  logic [31:0] dmem [16];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  logic [15:0] now_m = '0;
  logic [15:0] lf_m = 16'hACE1;

  logic [31:0] e_saddr, e_daddr, e_w2, e_w3, e_w0, e_w1;
  bit          e_wb2, e_wb3;

  always #5 clk = ~clk;

  tfhb_builder u_tfhb_builder (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_flow_i(req_flow), .req_time_i(req_time),
    .desc_rd_en_o(drd_en), .desc_addr_o(daddr), .desc_rd_data_i(drd_data),
    .desc_wr_en_o(dwr_en), .desc_wr_data_o(dwr_data),
    .alist_rd_en_o(ard_en), .alist_addr_o(aaddr), .alist_rd_data_i(ard_data),
    .tx_valid_o(tx_valid), .tx_port_o(tx_port), .tx_proto_o(tx_proto),
    .tx_tos_o(tx_tos), .tx_sport_o(tx_sport), .tx_dport_o(tx_dport),
    .tx_saddr_o(tx_saddr), .tx_daddr_o(tx_daddr)
  );

  always @(posedge clk) begin
    if (drd_en) drd_data <= dmem[daddr[3:0]];
    if (dwr_en) dmem[daddr[3:0]] <= dwr_data;
    if (ard_en) ard_data <= 32'hA000_0000 | {16'h0, aaddr};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // model of R4..R7 for one list; returns address word and write-back word
  task automatic pick(input logic [31:0] w, input bit rnd_mode,
                      output logic [31:0] addr_word, output logic [31:0] wb, output bit do_wb);
    logic [7:0]  idx, nx;
    logic [15:0] a;
    if (w[23:16] == 8'd0) idx = 8'd0;
    else if (rnd_mode)    idx = 8'(lf_m % {8'd0, w[23:16]});
    else                  idx = w[31:24];
    if (rnd_mode) lf_m = lf_next(lf_m);
    a = w[15:0] + {8'd0, idx};
    addr_word = 32'hA000_0000 | {16'h0, a};
    if (w[23:16] == 8'd0 || ({1'b0, w[31:24]} + 9'd1) >= {1'b0, w[23:16]}) nx = 8'd0;
    else nx = w[31:24] + 8'd1;
    wb = {nx, w[23:0]};
    do_wb = !rnd_mode;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    now_m = now_m + 16'd1;
  endtask

  task automatic run_req(input int f, input int ahead);
    logic [15:0] tgt;
    bit          seen;
    tgt  = now_m + 16'(ahead);
    e_w0 = dmem[4*f];
    e_w1 = dmem[4*f+1];
    pick(dmem[4*f+2], e_w0[5], e_saddr, e_w2, e_wb2);
    pick(dmem[4*f+3], e_w0[6], e_daddr, e_w3, e_wb3);
    @(negedge clk);
    chk("R8 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_flow = 15'(f); req_time = tgt;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy after accept", {31'd0, req_ready}, 32'd0);
    seen = 1'b0;
    if (ahead > 0) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (tx_valid) seen = 1'b1;
      end
      chk("R10 no release before target", {31'd0, seen}, 32'd0);
      chk("R8 busy while holding", {31'd0, req_ready}, 32'd0);
      for (int k = 1; k <= ahead; k++) begin
        tick_once();
        @(negedge clk);
        chk("R10 release on target tick", {31'd0, tx_valid}, {31'd0, k == ahead});
      end
    end else begin
      for (int i = 0; i < 20 && !seen; i++) begin
        @(negedge clk);
        if (tx_valid) seen = 1'b1;
      end
      chk("R10 release of past target", {31'd0, seen}, 32'd1);
    end
    chk("R2 port", {23'd0, tx_port}, {23'd0, e_w0[31:23]});
    chk("R2 proto", {24'd0, tx_proto}, {24'd0, e_w0[22:15]});
    chk("R2 tos", {24'd0, tx_tos}, {24'd0, e_w0[14:7]});
    chk("R3 ports", {tx_sport, tx_dport}, e_w1);
    chk(e_w0[5] ? "R6 source address" : "R4 source address", tx_saddr, e_saddr);
    chk(e_w0[6] ? "R6 destination address" : "R4 destination address", tx_daddr, e_daddr);
    @(negedge clk);
    chk("R10 single pulse", {31'd0, tx_valid}, 32'd0);
    if (e_wb2) chk("R5 source index write-back", dmem[4*f+2], e_w2);
    if (e_wb3) chk("R5 destination index write-back", dmem[4*f+3], e_w3);
  endtask

  initial begin
    // flow 0: both lists linear; reserved bits set
    dmem[0]  = {9'h1A5, 8'h11, 8'h2C, 2'b00, 5'h1F};
    dmem[1]  = {16'h1234, 16'hABCD};
    dmem[2]  = {8'd1, 8'd3, 16'h0010};
    dmem[3]  = {8'd2, 8'd3, 16'h0040};
    // flow 1: both random
    dmem[4]  = {9'h003, 8'h06, 8'h00, 2'b11, 5'h00};
    dmem[5]  = {16'h0050, 16'h1F90};
    dmem[6]  = {8'd0, 8'd5, 16'h0080};
    dmem[7]  = {8'd7, 8'd7, 16'h00C0};
    // flow 2: source random with empty list, destination linear with empty list (R7)
    dmem[8]  = {9'h100, 8'hFF, 8'h80, 2'b01, 5'h0A};
    dmem[9]  = {16'hFFFF, 16'h0001};
    dmem[10] = {8'd9, 8'd0, 16'h0020};
    dmem[11] = {8'd3, 8'd0, 16'h0030};
    // flow 3: source linear single entry, destination random
    dmem[12] = {9'h0FF, 8'h3A, 8'h55, 2'b10, 5'h00};
    dmem[13] = {16'h0800, 16'h0801};
    dmem[14] = {8'd0, 8'd1, 16'hFFFE};
    dmem[15] = {8'd0, 8'd4, 16'h0060};

    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no tx in reset", {31'd0, tx_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no descriptor read while idle", {31'd0, drd_en}, 32'd0);

    for (int v = 0; v < NV; v++)
      run_req(int'(VEC[v][17:16]), int'($signed(VEC[v][15:0])));

    // R9: hold tick to bring the counter close to its wrap, then release across it
    @(negedge clk); tick = 1'b1;
    while (now_m != 16'hFFFC) begin
      @(negedge clk);
      now_m = now_m + 16'd1;
    end
    tick = 1'b0;
    run_req(0, 6);
    // R10: a target far in the past releases without any tick
    run_req(3, -16'sh7000);
    // R6/R7: a repeat of the empty-list flow after the LFSR has moved
    run_req(2, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule